// File: doc/BRIEF.md
# Flash command interface controller

This block is the command front end of a small NOR-style flash store. Bus write cycles (chip enable and write enable low together on a rising clock edge) carry command bytes that the block decodes to pick what a read returns: array contents, the status byte, identification and lock information, or a short query signature. Two-byte sequences start program and erase operations on a small internal byte array split into equal blocks. Each block has a lock input, and a supply-valid input stands in for the programming voltage check.

A program or erase runs as a number of fixed-length internal steps. While it runs, only a few commands are accepted. A suspend request takes effect at the next step boundary, and a resume continues from the point where the operation stopped. Error flags are sticky until they are cleared explicitly. Reads are combinational from registered state and are gated by chip enable and output enable.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The status byte has this layout: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply error, bit 2 program suspended, bit 1 lock error, bit 0 zero. Bit 7 and the `ready` port are 0 while an operation runs and 1 otherwise. After reset the status byte is 80h. With the default parameters a program stays busy for 4 cycles after its data write and an erase for 8 cycles after its confirm write.
- R2: Program is 40h followed by a data write at the target address. The stored byte becomes the old byte AND the data byte, so writing a 1 over a 0 leaves the 0 in place and sets no error bit.
- R3: If the supply-valid input is low when a program or erase is confirmed, bit 3 is set (bit 5 is also set for an erase) and the array is not changed. If the supply drops at any time during a running operation, the operation completes with bit 4 (program) or bit 5 (erase) set and the array unchanged.
- R4: A program or erase aimed at a block whose lock input is high sets bit 1 and does not start. The array stays unchanged and the block stays ready.
- R5: While an operation runs, only 70h (read status), B0h (suspend) and D0h (resume, which has no effect here) are accepted. Every other byte is ignored, so reads keep returning status.
- R6: A suspend takes effect at the next internal step boundary. At that point `susp_pulse` is high for exactly one cycle, bit 7 reads 1, and bit 2 (program) or bit 6 (erase) reads 1. Reads return status until another read-mode command is written.
- R7: While suspended, only FFh, 70h, 90h, 98h and D0h are accepted; any other byte, including 40h, is ignored. In array mode, a read of the suspended block returns the status byte, and a read of any other block returns its data.
- R8: D0h while suspended resumes the operation. Bits 2 and 6 clear, bit 7 reads 0, reads return status, and the operation then completes with its original address and data.
- R9: Error bits 5, 4, 3 and 1 stay set until 50h is written while idle, and 50h clears all four of them. After an operation ends, reads keep returning status until a read-mode command is written.
- R10: Erase is 20h followed by D0h at any address in the block, and it sets every byte of that block to FFh while other blocks keep their data. Any byte other than D0h after 20h sets bits 5 and 4 and starts nothing.
- R11: FFh selects array reads (the reset mode), and 70h selects status reads. 90h selects identification reads, which return A5h at block offset 0, 3Ch at offset 1, the addressed block's lock bit in bit 0 at offset 2, and 00h elsewhere. 98h selects query reads, which return 51h, 52h and 59h at offsets 0, 1 and 2 and 00h elsewhere.
- R12: If a suspend request is still pending at the boundary that ends the last step, the operation completes, no suspended pulse is raised, and the status shows ready with no suspend bit set.
- R13: `rdata` is 00h whenever chip enable or output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable; a command is taken on each edge where ce_n and we_n are both low |
| oe_n | input | 1 | Active-low output enable |
| addr | input | $clog2(NBLK*BLK_WORDS) | Byte address; the upper bits select the block |
| wdata | input | 8 | Command or program data byte |
| vpp_ok | input | 1 | Supply-valid indication |
| blk_lock | input | NBLK | Per-block lock bits |
| rdata | output | 8 | Read data as selected by the read mode |
| ready | output | 1 | High when no operation is running |
| susp_pulse | output | 1 | One-cycle pulse when a suspend takes effect |

## Verification
The assertions assume that each command occupies exactly one clock with ce_n and we_n low, so a held write enable would be taken as repeated commands. They also assume reset is held for at least one edge before any traffic. The bench drives every write as a single-cycle strobe from the falling edge and performs reads only while we_n is high. It changes vpp_ok and blk_lock only between cycles, so the supply and lock checks see a clean level at confirm and on every step.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_PROG      = 8'h40;
    localparam logic [7:0] CMD_ERASE     = 8'h20;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0] CMD_RD_ID     = 8'h90;
    localparam logic [7:0] CMD_RD_QRY    = 8'h98;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PSETUP,
        ST_ESETUP,
        ST_BUSY,
        ST_SUSP
    } ctl_st_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_ID,
        RM_QRY
    } rd_mode_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_ARRAY,
        OP_RD_STATUS,
        OP_CLR,
        OP_PSETUP,
        OP_ESETUP,
        OP_CONFIRM,
        OP_SUSPEND,
        OP_RD_ID,
        OP_RD_QRY,
        OP_OTHER
    } cmd_e;

endpackage

// File: rtl/fcc_decoder.sv
module fcc_decoder
    import fcc_pkg::*;
(
    input  logic       wr_stb,
    input  logic [7:0] wbyte,
    output cmd_e       cmd
);

    always_comb begin
        cmd = OP_NONE;
        if (wr_stb) begin
            case (wbyte)
                CMD_RD_ARRAY:  cmd = OP_RD_ARRAY;
                CMD_RD_STATUS: cmd = OP_RD_STATUS;
                CMD_CLR_STAT:  cmd = OP_CLR;
                CMD_PROG:      cmd = OP_PSETUP;
                CMD_ERASE:     cmd = OP_ESETUP;
                CMD_CONFIRM:   cmd = OP_CONFIRM;
                CMD_SUSPEND:   cmd = OP_SUSPEND;
                CMD_RD_ID:     cmd = OP_RD_ID;
                CMD_RD_QRY:    cmd = OP_RD_QRY;
                default:       cmd = OP_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter  int NBLK      = 4,
    parameter  int BLK_WORDS = 8,
    localparam int WORDS     = NBLK * BLK_WORDS,
    localparam int AW        = $clog2(WORDS),
    localparam int BW        = $clog2(BLK_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          erase_en,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wbyte,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rbyte
);

    logic [7:0]       mem_q [WORDS];
    logic [7:0]       mem_d [WORDS];
    logic [AW-BW-1:0] eblk;

    assign eblk  = waddr[AW-1:BW];
    assign rbyte = mem_q[raddr];

    always_comb begin
        mem_d = mem_q;
        if (prog_en) begin
            mem_d[waddr] = mem_q[waddr] & wbyte;
        end
        if (erase_en) begin
            for (int i = 0; i < BLK_WORDS; i++) begin
                mem_d[{eblk, BW'(i)}] = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '1};
        end else begin
            mem_q <= mem_d;
        end
    end

    AST_PROG_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem_q[$past(waddr)] & ~$past(wbyte)) == 8'h00)); // R2

    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem_q[{$past(eblk), BW'(0)}] == 8'hFF)); // R10

endmodule

// File: rtl/fcc_rdmux.sv
module fcc_rdmux
    import fcc_pkg::*;
#(
    parameter  int         NBLK      = 4,
    parameter  int         BLK_WORDS = 8,
    parameter  logic [7:0] ID_MFR    = 8'hA5,
    parameter  logic [7:0] ID_DEV    = 8'h3C,
    localparam int         AW        = $clog2(NBLK * BLK_WORDS),
    localparam int         BW        = $clog2(BLK_WORDS)
) (
    input  rd_mode_e         mode,
    input  logic             in_susp,
    input  logic [AW-1:0]    raddr,
    input  logic [AW-BW-1:0] susp_blk,
    input  logic [7:0]       status,
    input  logic [7:0]       arr_byte,
    input  logic [NBLK-1:0]  lock,
    output logic [7:0]       dout
);

    logic [BW-1:0]    off;
    logic [AW-BW-1:0] rblk;

    assign off  = raddr[BW-1:0];
    assign rblk = raddr[AW-1:BW];

    always_comb begin
        dout = 8'h00;
        unique case (mode)
            RM_ARRAY: begin
                if (in_susp && (rblk == susp_blk)) dout = status;
                else                               dout = arr_byte;
            end
            RM_STATUS: dout = status;
            RM_ID: begin
                case (int'(off))
                    0:       dout = ID_MFR;
                    1:       dout = ID_DEV;
                    2:       dout = {7'b0, lock[rblk]};
                    default: dout = 8'h00;
                endcase
            end
            RM_QRY: begin
                case (int'(off))
                    0:       dout = 8'h51;
                    1:       dout = 8'h52;
                    2:       dout = 8'h59;
                    default: dout = 8'h00;
                endcase
            end
            default: dout = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int         NBLK        = 4,
    parameter int         BLK_WORDS   = 8,
    parameter int         STEP_CYC    = 2,
    parameter int         PROG_STEPS  = 2,
    parameter int         ERASE_STEPS = 4,
    parameter logic [7:0] ID_MFR      = 8'hA5,
    parameter logic [7:0] ID_DEV      = 8'h3C
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ce_n,
    input  logic                                  we_n,
    input  logic                                  oe_n,
    input  logic [$clog2(NBLK*BLK_WORDS)-1:0]     addr,
    input  logic [7:0]                            wdata,
    input  logic                                  vpp_ok,
    input  logic [NBLK-1:0]                       blk_lock,
    output logic [7:0]                            rdata,
    output logic                                  ready,
    output logic                                  susp_pulse
);

    localparam int AW    = $clog2(NBLK * BLK_WORDS);
    localparam int BW    = $clog2(BLK_WORDS);
    localparam int CW    = $clog2(STEP_CYC + 1);
    localparam int MAXST = (PROG_STEPS > ERASE_STEPS) ? PROG_STEPS : ERASE_STEPS;
    localparam int SW    = $clog2(MAXST + 1);

    localparam logic [CW-1:0] CYC_LAST  = CW'(STEP_CYC - 1);
    localparam logic [SW-1:0] PROG_LAST = SW'(PROG_STEPS - 1);
    localparam logic [SW-1:0] ERAS_LAST = SW'(ERASE_STEPS - 1);

    typedef struct packed {
        ctl_st_e       st;
        rd_mode_e      mode;
        logic          is_erase;
        logic          e_fail;
        logic          p_fail;
        logic          v_err;
        logic          l_err;
        logic          susp_req;
        logic          susp_pulse;
        logic          run_fail;
        logic [CW-1:0] cyc;
        logic [SW-1:0] step;
        logic [AW-1:0] op_addr;
        logic [7:0]    op_data;
    } ctl_t;

    ctl_t          c_q, c_d;
    cmd_e          cmd;
    logic          wr_stb;
    logic          prog_en, erase_en;
    logic          go_start, go_erase;
    logic [SW-1:0] last_step;
    logic [7:0]    sr;
    logic [7:0]    arr_byte;
    logic [7:0]    mux_out;
    logic [3:0]    err_q;
    logic          resume_acc;

    assign wr_stb = !ce_n && !we_n;

    fcc_decoder u_dec (
        .wr_stb (wr_stb),
        .wbyte  (wdata),
        .cmd    (cmd)
    );

    assign last_step  = c_q.is_erase ? ERAS_LAST : PROG_LAST;
    assign ready      = (c_q.st != ST_BUSY);
    assign susp_pulse = c_q.susp_pulse;
    assign sr = {ready,
                 (c_q.st == ST_SUSP) &&  c_q.is_erase,
                 c_q.e_fail, c_q.p_fail, c_q.v_err,
                 (c_q.st == ST_SUSP) && !c_q.is_erase,
                 c_q.l_err, 1'b0};
    assign err_q      = {c_q.e_fail, c_q.p_fail, c_q.v_err, c_q.l_err};
    assign resume_acc = (c_q.st == ST_SUSP) && (cmd == OP_CONFIRM);

    always_comb begin
        c_d            = c_q;
        c_d.susp_pulse = 1'b0;
        prog_en        = 1'b0;
        erase_en       = 1'b0;
        go_start       = 1'b0;
        go_erase       = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                case (cmd)
                    OP_RD_ARRAY:  c_d.mode = RM_ARRAY;
                    OP_RD_STATUS: c_d.mode = RM_STATUS;
                    OP_RD_ID:     c_d.mode = RM_ID;
                    OP_RD_QRY:    c_d.mode = RM_QRY;
                    OP_CLR: begin
                        c_d.e_fail = 1'b0;
                        c_d.p_fail = 1'b0;
                        c_d.v_err  = 1'b0;
                        c_d.l_err  = 1'b0;
                    end
                    OP_PSETUP: begin
                        c_d.st   = ST_PSETUP;
                        c_d.mode = RM_STATUS;
                    end
                    OP_ESETUP: begin
                        c_d.st   = ST_ESETUP;
                        c_d.mode = RM_STATUS;
                    end
                    default: ;
                endcase
            end

            ST_PSETUP: begin
                if (cmd != OP_NONE) begin
                    go_start = 1'b1;
                end
            end

            ST_ESETUP: begin
                if (cmd == OP_CONFIRM) begin
                    go_start = 1'b1;
                    go_erase = 1'b1;
                end else if (cmd != OP_NONE) begin
                    c_d.st     = ST_IDLE;
                    c_d.e_fail = 1'b1;
                    c_d.p_fail = 1'b1;
                end
            end

            ST_BUSY: begin
                if (cmd == OP_RD_STATUS) c_d.mode = RM_STATUS;
                if (cmd == OP_SUSPEND)   c_d.susp_req = 1'b1;
                if (!vpp_ok)             c_d.run_fail = 1'b1;
                if (c_q.cyc == CYC_LAST) begin
                    c_d.cyc = '0;
                    if (c_q.step == last_step) begin
                        c_d.st       = ST_IDLE;
                        c_d.susp_req = 1'b0;
                        if (c_q.run_fail || !vpp_ok) begin
                            if (c_q.is_erase) c_d.e_fail = 1'b1;
                            else              c_d.p_fail = 1'b1;
                        end else begin
                            prog_en  = !c_q.is_erase;
                            erase_en =  c_q.is_erase;
                        end
                    end else begin
                        c_d.step = c_q.step + SW'(1);
                        if (c_q.susp_req || (cmd == OP_SUSPEND)) begin
                            c_d.st         = ST_SUSP;
                            c_d.susp_req   = 1'b0;
                            c_d.susp_pulse = 1'b1;
                        end
                    end
                end else begin
                    c_d.cyc = c_q.cyc + CW'(1);
                end
            end

            ST_SUSP: begin
                case (cmd)
                    OP_RD_ARRAY:  c_d.mode = RM_ARRAY;
                    OP_RD_STATUS: c_d.mode = RM_STATUS;
                    OP_RD_ID:     c_d.mode = RM_ID;
                    OP_RD_QRY:    c_d.mode = RM_QRY;
                    OP_CONFIRM: begin
                        c_d.st   = ST_BUSY;
                        c_d.mode = RM_STATUS;
                        c_d.cyc  = '0;
                    end
                    default: ;
                endcase
            end

            default: c_d.st = ST_IDLE;
        endcase

        if (go_start) begin
            c_d.st       = ST_IDLE;
            c_d.is_erase = go_erase;
            if (!vpp_ok) begin
                c_d.v_err = 1'b1;
                if (go_erase) c_d.e_fail = 1'b1;
            end else if (blk_lock[addr[AW-1:BW]]) begin
                c_d.l_err = 1'b1;
            end else begin
                c_d.st       = ST_BUSY;
                c_d.cyc      = '0;
                c_d.step     = '0;
                c_d.run_fail = 1'b0;
                c_d.susp_req = 1'b0;
                c_d.op_addr  = addr;
                c_d.op_data  = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    fcc_array #(
        .NBLK      (NBLK),
        .BLK_WORDS (BLK_WORDS)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .waddr    (c_q.op_addr),
        .wbyte    (c_q.op_data),
        .raddr    (addr),
        .rbyte    (arr_byte)
    );

    fcc_rdmux #(
        .NBLK      (NBLK),
        .BLK_WORDS (BLK_WORDS),
        .ID_MFR    (ID_MFR),
        .ID_DEV    (ID_DEV)
    ) u_mux (
        .mode     (c_q.mode),
        .in_susp  (c_q.st == ST_SUSP),
        .raddr    (addr),
        .susp_blk (c_q.op_addr[AW-1:BW]),
        .status   (sr),
        .arr_byte (arr_byte),
        .lock     (blk_lock),
        .dout     (mux_out)
    );

    assign rdata = (!ce_n && !oe_n) ? mux_out : 8'h00;

    AST_READY_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wr_stb)); // R1

    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_BUSY) |-> (c_q.mode == RM_STATUS)); // R5

    AST_LOCK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.l_err) |-> ready); // R4

    AST_SUSP_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |=> !susp_pulse); // R6

    AST_SUSP_FLAGS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |-> (sr[7] && (sr[2] || sr[6]))); // R6

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(resume_acc) |-> (!ready && !sr[2] && !sr[6])); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd == OP_CLR) |-> (($past(err_q) & ~err_q) == 4'b0)); // R9

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          vpp_ok = 1'b1;
    logic [3:0]    blk_lock = '0;
    logic [7:0]    rdata;
    logic          ready;
    logic          susp_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .wdata      (wdata),
        .vpp_ok     (vpp_ok),
        .blk_lock   (blk_lock),
        .rdata      (rdata),
        .ready      (ready),
        .susp_pulse (susp_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
        ce_n = 1'b0; we_n = 1'b0; wdata = d; addr = a;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1;
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        logic [7:0] v;
        n = 0;
        rd(0, v);
        while (!v[7] && n < 100) begin
            @(negedge clk);
            n++;
            rd(0, v);
        end
    endtask

    task automatic count_pulses(input int cycles, output int p);
        p = 0;
        for (int i = 0; i < cycles; i++) begin
            #1;
            if (susp_pulse) p++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(0, v);                         chk("R11 reset array read", v, 8'hFF);
        ce_n = 1'b0; oe_n = 1'b1; addr = 0; #1;
        chk("R13 oe_n high gives zero", rdata, 0);
        ce_n = 1'b1;
        wr(8'h70, 0); rd(0, v);           chk("R1 reset status", v, 8'h80);
        chk("R1 ready port at reset", ready, 1);
    endtask

    task automatic t_program;
        logic [7:0] v; int n;
        wr(8'h40, 0); wr(8'hA5, 0);
        rd(0, v);                         chk("R1 busy status", v, 8'h00);
        chk("R1 ready port low", ready, 0);
        wait_ready(n);                    chk("R1 program duration", n, 4);
        rd(0, v);                         chk("R2 program no error", v, 8'h80);
        wr(8'hFF, 0); rd(0, v);           chk("R2 programmed byte", v, 8'hA5);
        wr(8'h40, 0); wr(8'hFF, 0); wait_ready(n);
        rd(0, v);                         chk("R2 ones over zeros no error", v, 8'h80);
        wr(8'hFF, 0); rd(0, v);           chk("R2 ones over zeros unchanged", v, 8'hA5);
        wr(8'h40, 0); wr(8'h0F, 0); wait_ready(n);
        wr(8'hFF, 0); rd(0, v);           chk("R2 AND of old and new", v, 8'h05);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v; int n;
        wr(8'h40, 8); wr(8'h00, 8);
        wr(8'hFF, 0); rd(0, v);           chk("R5 read array ignored while busy", v, 8'h00);
        wr(8'h90, 0); rd(0, v);           chk("R5 id mode ignored while busy", v, 8'h00);
        wait_ready(n);
        rd(0, v);                         chk("R9 status mode after completion", v, 8'h80);
        wr(8'hFF, 0); rd(8, v);           chk("R5 program completed", v, 8'h00);
    endtask

    task automatic t_supply;
        logic [7:0] v; int n;
        vpp_ok = 1'b0;
        wr(8'h40, 16); wr(8'h11, 16);
        rd(0, v);                         chk("R3 supply error on program", v, 8'h88);
        vpp_ok = 1'b1;
        wr(8'hFF, 0); rd(16, v);          chk("R3 array untouched", v, 8'hFF);
        wr(8'h70, 0); rd(0, v);           chk("R9 error sticky", v, 8'h88);
        wr(8'h50, 0); rd(0, v);           chk("R9 clear status", v, 8'h80);
        vpp_ok = 1'b0;
        wr(8'h20, 16); wr(8'hD0, 16);
        rd(0, v);                         chk("R3 supply error on erase", v, 8'hA8);
        vpp_ok = 1'b1;
        wr(8'h50, 0);
        wr(8'h40, 17); wr(8'h00, 17);
        vpp_ok = 1'b0; @(negedge clk); vpp_ok = 1'b1;
        wait_ready(n);
        rd(0, v);                         chk("R3 supply drop fails program", v, 8'h90);
        wr(8'hFF, 0); rd(17, v);          chk("R3 dropped program leaves cell", v, 8'hFF);
        wr(8'h50, 0);
        wr(8'h70, 0); rd(0, v);           chk("R9 cleared after drop", v, 8'h80);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        blk_lock = 4'b1000;
        @(negedge clk);
        wr(8'h40, 24); wr(8'h00, 24);
        rd(0, v);                         chk("R4 lock error", v, 8'h82);
        wr(8'hFF, 0); rd(24, v);          chk("R4 locked block unchanged", v, 8'hFF);
        wr(8'h90, 0); rd(26, v);          chk("R11 lock bit read", v, 8'h01);
        rd(2, v);                         chk("R11 unlocked bit read", v, 8'h00);
        rd(0, v);                         chk("R11 id offset 0", v, 8'hA5);
        rd(1, v);                         chk("R11 id offset 1", v, 8'h3C);
        wr(8'h98, 0); rd(0, v);           chk("R11 query offset 0", v, 8'h51);
        rd(2, v);                         chk("R11 query offset 2", v, 8'h59);
        wr(8'h50, 0); wr(8'h70, 0); rd(0, v);
        chk("R9 lock error cleared", v, 8'h80);
    endtask

    task automatic t_erase;
        logic [7:0] v; int n;
        wr(8'h20, 3); wr(8'hD0, 3);
        wait_ready(n);                    chk("R1 erase duration", n, 8);
        rd(0, v);                         chk("R10 erase no error", v, 8'h80);
        wr(8'hFF, 0); rd(0, v);           chk("R10 erased byte", v, 8'hFF);
        rd(8, v);                         chk("R10 other block kept", v, 8'h00);
        wr(8'h20, 0); wr(8'h40, 0);
        rd(0, v);                         chk("R10 bad confirm sequence", v, 8'hB0);
        wr(8'h50, 0); rd(0, v);           chk("R9 clear after sequence error", v, 8'h80);
    endtask

    task automatic t_prog_susp;
        logic [7:0] v; int n, p;
        wr(8'h40, 9); wr(8'h3C, 9); wr(8'hB0, 9);
        count_pulses(8, p);               chk("R6 one suspend pulse", p, 1);
        rd(0, v);                         chk("R6 program suspended status", v, 8'h84);
        wr(8'hFF, 0); rd(9, v);           chk("R7 suspended block gives status", v, 8'h84);
        rd(0, v);                         chk("R7 other block readable", v, 8'hFF);
        wr(8'h40, 0); wr(8'h00, 0);
        rd(0, v);                         chk("R7 program ignored in suspend", v, 8'hFF);
        chk("R7 still ready in suspend", ready, 1);
        wr(8'hD0, 0); rd(0, v);           chk("R8 resume status", v, 8'h00);
        wait_ready(n);
        rd(0, v);                         chk("R8 resumed completes", v, 8'h80);
        wr(8'hFF, 0); rd(9, v);           chk("R8 resumed data", v, 8'h3C);
    endtask

    task automatic t_erase_susp;
        logic [7:0] v; int n, p;
        wr(8'h40, 16); wr(8'h00, 16); wait_ready(n);
        wr(8'h20, 16); wr(8'hD0, 16); wr(8'hB0, 16);
        count_pulses(8, p);               chk("R6 erase suspend pulse", p, 1);
        rd(0, v);                         chk("R6 erase suspended status", v, 8'hC0);
        wr(8'h98, 0); rd(1, v);           chk("R7 query while suspended", v, 8'h52);
        wr(8'hD0, 0); rd(0, v);           chk("R8 erase resume status", v, 8'h00);
        wait_ready(n);
        wr(8'hFF, 0); rd(16, v);          chk("R8 erase completed after resume", v, 8'hFF);
    endtask

    task automatic t_late_susp;
        logic [7:0] v; int p;
        wr(8'h40, 10); wr(8'h5A, 10);
        @(negedge clk); @(negedge clk);
        wr(8'hB0, 10);
        count_pulses(6, p);               chk("R12 no pulse on last step", p, 0);
        rd(0, v);                         chk("R12 completed not suspended", v, 8'h80);
        wr(8'hFF, 0); rd(10, v);          chk("R12 data written", v, 8'h5A);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_busy_ignore();
        t_supply();
        t_lock();
        t_erase();
        t_prog_susp();
        t_erase_susp();
        t_late_susp();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule